// File: doc/BRIEF.md
# Floating-Point Data-Move Decoder

This block sits in the decode stage of a RISC core. It takes a 16-bit instruction word and, one clock later, reports what a floating-point data move should do. The report covers the operation class, the floating-point source and destination registers, whether the transfer is one 32-bit word or a 64-bit register pair, the effective memory address, and the written-back value of the general-purpose base register. If the instruction cannot run, the report carries an exception code instead. The block also executes the register-bank toggle instruction by returning the new value of the bank-select bit.

Two mode bits from the floating-point status register select how a move decodes. The transfer-size bit chooses between single and pair transfers. The precision bit makes pair transfers, negate and bank toggle illegal. The same bit pattern can therefore be a 32-bit move or a 64-bit move. A pair register field uses its upper three bits as an even register number and its low bit to select the extended bank.

The caller supplies two general-purpose values on the same cycle as the word: the base register named by `base_idx_o` and R0. The caller then applies the reported effects. The register file, memory and arithmetic are outside the block.

Top module: `fmv_dec`

## Requirements
- R1: All outputs are registered. The result for a word presented with `valid_i`=1 appears on the outputs one clock edge later. After a cycle with `valid_i`=0, and during reset, every output is 0.
- R2: Word 1111nnnnmmmm1100 with size mode 0 is a single register move:
  - op code 1, source index m, destination index n;
  - `freg_we_o`=1 and no memory access.
- R3: Single loads with size mode 0 give op code 2, destination index n, `mem_rd_o`=1 and `base_idx_o`=m:
  - low nibble 1000: address = base;
  - low nibble 1001: address = base, and base + 4 is written back;
  - low nibble 0110: address = R0 + base.
- R4: Single stores with size mode 0 give op code 3, source index m, `mem_wr_o`=1 and `base_idx_o`=n:
  - low nibble 1010: address = base;
  - low nibble 1011: address = base − 4, and the same value is written back;
  - low nibble 0111: address = R0 + base.
- R5: With size mode 1 and precision mode 0, the move, load and store words above become pair transfers:
  - `pair_o`=1 and the write-back step is 8;
  - a register field's bits [3:1] give index {bits[3:1],0};
  - the field's bit 0 (instruction bit 8 for n, bit 4 for m) is the bank flag.
- R6: A matched move, load or store with size mode 1 and precision mode 1 gives exception code 1. So does negate or bank toggle with precision mode 1. In these cases there are no effects.
- R7: Any word that is not one of the listed patterns gives exception code 1 and no effects, whatever the disable flags are. This covers a top nibble other than 1111 and the unused low nibbles.
- R8: A matched word with the FPU disabled raises an exception and has no effects. The exception takes priority over exception code 1.
  - In a delay slot the code is 3.
  - Outside a delay slot the code is 2.
- R9: Word 1111nnnn01001101 with precision mode 0 is negate:
  - op code 4, with source and destination both n;
  - `freg_we_o`=1 and no memory access.
- R10: Word 1111101111111101 with precision mode 0 is bank toggle: op code 5, `bank_we_o`=1 and `bank_val_o` = inverted `bank_sel_i`. No other word asserts `bank_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| fpu_dis_i | input | 1 | FPU disabled flag from status register |
| slot_i | input | 1 | Instruction is in a delay slot |
| size_mode_i | input | 1 | Transfer-size mode bit (1 = pair) |
| prec_mode_i | input | 1 | Precision mode bit |
| bank_sel_i | input | 1 | Current register-bank select bit |
| base_i | input | 32 | Value of the base register named by base_idx_o |
| r0_i | input | 32 | Value of R0 |
| valid_o | output | 1 | Result valid |
| op_o | output | 3 | Op code: 0 none, 1 move, 2 load, 3 store, 4 negate, 5 bank toggle |
| exc_o | output | 2 | Exception code: 0 none, 1 illegal, 2 FPU disabled, 3 slot FPU disabled |
| pair_o | output | 1 | 64-bit pair transfer |
| src_bank_o | output | 1 | Source is in the extended bank |
| src_idx_o | output | 4 | Source register index |
| dst_bank_o | output | 1 | Destination is in the extended bank |
| dst_idx_o | output | 4 | Destination register index |
| freg_we_o | output | 1 | Floating-point register write |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_o | output | 32 | Effective address |
| base_idx_o | output | 4 | General-purpose base register number |
| base_we_o | output | 1 | Base register write-back |
| base_val_o | output | 32 | Write-back value |
| bank_we_o | output | 1 | Bank-select bit update |
| bank_val_o | output | 1 | New bank-select bit |

## Verification
Every result of this block is due exactly one rising edge after its word is presented. This holds for the decode, the address, the write-back value, the exception code and the bank bit alike.

The bench drives each vector at a falling edge and holds it across the next rising edge. It compares the whole output set at the following falling edge against a value computed from the same inputs. The inputs stay stable, so no check depends on process order at the edge.

The assertions that reach back to inputs use `$past` of depth one, which matches this single register stage.

// File: rtl/fmv_pkg.sv
`timescale 1ns/1ps
package fmv_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MOVE  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_NEG   = 3'd4,
    OP_BANK  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_ILL  = 2'd1,
    EXC_FPU  = 2'd2,
    EXC_SLOT = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    AM_NONE = 3'd0,
    AM_IND  = 3'd1,
    AM_POST = 3'd2,
    AM_PRE  = 3'd3,
    AM_IDX  = 3'd4
  } am_e;
endpackage

// File: rtl/fmv_match.sv
`timescale 1ns/1ps
module fmv_match
  import fmv_pkg::*;
(
  input  logic [15:0] instr_i,
  output logic        hit_o,
  output logic        mv_o,
  output op_e         op_o,
  output am_e         am_o,
  output logic [3:0]  n_o,
  output logic [3:0]  m_o
);
  assign n_o = instr_i[11:8];
  assign m_o = instr_i[7:4];

  always_comb begin
    hit_o = 1'b0;
    mv_o  = 1'b0;
    op_o  = OP_NONE;
    am_o  = AM_NONE;
    if (instr_i[15:12] == 4'hF) begin
      unique case (instr_i[3:0])
        4'hC: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_MOVE; end
        4'h8: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_LOAD;  am_o = AM_IND;  end
        4'h9: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_LOAD;  am_o = AM_POST; end
        4'h6: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_LOAD;  am_o = AM_IDX;  end
        4'hA: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_STORE; am_o = AM_IND;  end
        4'hB: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_STORE; am_o = AM_PRE;  end
        4'h7: begin hit_o = 1'b1; mv_o = 1'b1; op_o = OP_STORE; am_o = AM_IDX;  end
        4'hD: begin
          if (instr_i[7:4] == 4'h4) begin
            hit_o = 1'b1; op_o = OP_NEG;
          end else if (instr_i[11:4] == 8'hBF) begin
            hit_o = 1'b1; op_o = OP_BANK;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fmv_agen.sv
`timescale 1ns/1ps
module fmv_agen
  import fmv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int SGL_BYTES = 4
) (
  input  am_e             am_i,
  input  logic            pair_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] r0_i,
  output logic [XLEN-1:0] addr_o,
  output logic            wb_o,
  output logic [XLEN-1:0] wb_val_o
);
  localparam int PAIR_BYTES = 2 * SGL_BYTES;
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SGL_BYTES);
  localparam logic [XLEN-1:0] STEP_P = XLEN'(PAIR_BYTES);

  logic [XLEN-1:0] step;
  assign step = pair_i ? STEP_P : STEP_S;

  always_comb begin
    addr_o   = '0;
    wb_o     = 1'b0;
    wb_val_o = '0;
    unique case (am_i)
      AM_IND:  addr_o = base_i;
      AM_POST: begin addr_o = base_i; wb_o = 1'b1; wb_val_o = base_i + step; end
      AM_PRE:  begin addr_o = base_i - step; wb_o = 1'b1; wb_val_o = base_i - step; end
      AM_IDX:  addr_o = base_i + r0_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/fmv_exc.sv
`timescale 1ns/1ps
module fmv_exc
  import fmv_pkg::*;
(
  input  logic hit_i,
  input  logic legal_i,
  input  logic dis_i,
  input  logic slot_i,
  output exc_e exc_o
);
  // disable checks outrank mode legality for matched words
  always_comb begin
    if (!hit_i)                exc_o = EXC_ILL;
    else if (dis_i && slot_i)  exc_o = EXC_SLOT;
    else if (dis_i)            exc_o = EXC_FPU;
    else if (!legal_i)         exc_o = EXC_ILL;
    else                       exc_o = EXC_NONE;
  end
endmodule

// File: rtl/fmv_regsel.sv
`timescale 1ns/1ps
module fmv_regsel #(
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] field_i,
  input  logic            pair_i,
  input  logic            used_i,
  output logic            bank_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    bank_o = 1'b0;
    idx_o  = '0;
    if (used_i) begin
      if (pair_i) begin
        bank_o = field_i[0];
        idx_o  = {field_i[IDXW-1:1], 1'b0};
      end else begin
        idx_o  = field_i;
      end
    end
  end
endmodule

// File: rtl/fmv_dec.sv
`timescale 1ns/1ps
module fmv_dec
  import fmv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int SGL_BYTES = 4,
  parameter int IDXW      = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [15:0]     instr_i,
  input  logic            fpu_dis_i,
  input  logic            slot_i,
  input  logic            size_mode_i,
  input  logic            prec_mode_i,
  input  logic            bank_sel_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] r0_i,
  output logic            valid_o,
  output logic [2:0]      op_o,
  output logic [1:0]      exc_o,
  output logic            pair_o,
  output logic            src_bank_o,
  output logic [IDXW-1:0] src_idx_o,
  output logic            dst_bank_o,
  output logic [IDXW-1:0] dst_idx_o,
  output logic            freg_we_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [XLEN-1:0] addr_o,
  output logic [IDXW-1:0] base_idx_o,
  output logic            base_we_o,
  output logic [XLEN-1:0] base_val_o,
  output logic            bank_we_o,
  output logic            bank_val_o
);
  localparam int NSEL = 2;  // 0: source, 1: destination

  typedef struct packed {
    logic            valid;
    logic [2:0]      op;
    logic [1:0]      exc;
    logic            pair;
    logic            src_bank;
    logic [IDXW-1:0] src_idx;
    logic            dst_bank;
    logic [IDXW-1:0] dst_idx;
    logic            freg_we;
    logic            mem_rd;
    logic            mem_wr;
    logic [XLEN-1:0] addr;
    logic [IDXW-1:0] base_idx;
    logic            base_we;
    logic [XLEN-1:0] base_val;
    logic            bank_we;
    logic            bank_val;
  } res_t;

  logic            hit, mv, legal, go, pair, is_mem;
  op_e             op;
  am_e             am;
  exc_e            exc;
  logic [3:0]      fn, fm;
  logic [XLEN-1:0] ag_addr, ag_wb_val;
  logic            ag_wb;

  logic [NSEL-1:0][IDXW-1:0] sel_field;
  logic [NSEL-1:0][IDXW-1:0] sel_idx;
  logic [NSEL-1:0]           sel_used;
  logic [NSEL-1:0]           sel_bank;

  res_t res_d, res_q;

  fmv_match u_match (
    .instr_i (instr_i),
    .hit_o   (hit),
    .mv_o    (mv),
    .op_o    (op),
    .am_o    (am),
    .n_o     (fn),
    .m_o     (fm)
  );

  // data moves need narrow size or narrow precision; others need narrow precision
  assign legal = mv ? (!size_mode_i || !prec_mode_i) : !prec_mode_i;

  fmv_exc u_exc (
    .hit_i   (hit),
    .legal_i (legal),
    .dis_i   (fpu_dis_i),
    .slot_i  (slot_i),
    .exc_o   (exc)
  );

  assign go     = valid_i && (exc == EXC_NONE);
  assign pair   = go && mv && size_mode_i;
  assign is_mem = go && (op == OP_LOAD || op == OP_STORE);

  fmv_agen #(
    .XLEN      (XLEN),
    .SGL_BYTES (SGL_BYTES)
  ) u_agen (
    .am_i     (am),
    .pair_i   (pair),
    .base_i   (base_i),
    .r0_i     (r0_i),
    .addr_o   (ag_addr),
    .wb_o     (ag_wb),
    .wb_val_o (ag_wb_val)
  );

  assign sel_field[0] = (op == OP_NEG) ? IDXW'(fn) : IDXW'(fm);
  assign sel_field[1] = IDXW'(fn);
  assign sel_used[0]  = go && (op == OP_MOVE || op == OP_STORE || op == OP_NEG);
  assign sel_used[1]  = go && (op == OP_MOVE || op == OP_LOAD  || op == OP_NEG);

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    fmv_regsel #(.IDXW(IDXW)) u_sel (
      .field_i (sel_field[g]),
      .pair_i  (pair),
      .used_i  (sel_used[g]),
      .bank_o  (sel_bank[g]),
      .idx_o   (sel_idx[g])
    );
  end

  always_comb begin
    res_d          = '0;
    res_d.valid    = valid_i;
    res_d.exc      = valid_i ? exc : EXC_NONE;
    res_d.op       = go ? op : OP_NONE;
    res_d.pair     = pair;
    res_d.src_bank = sel_bank[0];
    res_d.src_idx  = sel_idx[0];
    res_d.dst_bank = sel_bank[1];
    res_d.dst_idx  = sel_idx[1];
    res_d.freg_we  = sel_used[1];
    res_d.mem_rd   = go && (op == OP_LOAD);
    res_d.mem_wr   = go && (op == OP_STORE);
    if (is_mem) begin
      res_d.addr     = ag_addr;
      res_d.base_idx = (op == OP_LOAD) ? IDXW'(fm) : IDXW'(fn);
      res_d.base_we  = ag_wb;
      res_d.base_val = ag_wb ? ag_wb_val : '0;
    end
    res_d.bank_we  = go && (op == OP_BANK);
    res_d.bank_val = go && (op == OP_BANK) && !bank_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign valid_o    = res_q.valid;
  assign op_o       = res_q.op;
  assign exc_o      = res_q.exc;
  assign pair_o     = res_q.pair;
  assign src_bank_o = res_q.src_bank;
  assign src_idx_o  = res_q.src_idx;
  assign dst_bank_o = res_q.dst_bank;
  assign dst_idx_o  = res_q.dst_idx;
  assign freg_we_o  = res_q.freg_we;
  assign mem_rd_o   = res_q.mem_rd;
  assign mem_wr_o   = res_q.mem_wr;
  assign addr_o     = res_q.addr;
  assign base_idx_o = res_q.base_idx;
  assign base_we_o  = res_q.base_we;
  assign base_val_o = res_q.base_val;
  assign bank_we_o  = res_q.bank_we;
  assign bank_val_o = res_q.bank_val;
endmodule

// File: rtl/fmv_dec_chk.sv
`timescale 1ns/1ps
module fmv_dec_chk #(
  parameter int XLEN      = 32,
  parameter int SGL_BYTES = 4,
  parameter int IDXW      = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fpu_dis_i,
  input logic            slot_i,
  input logic            bank_sel_i,
  input logic [XLEN-1:0] base_i,
  input logic            valid_o,
  input logic [2:0]      op_o,
  input logic [1:0]      exc_o,
  input logic            pair_o,
  input logic [IDXW-1:0] src_idx_o,
  input logic [IDXW-1:0] dst_idx_o,
  input logic            freg_we_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic [XLEN-1:0] addr_o,
  input logic            base_we_o,
  input logic [XLEN-1:0] base_val_o,
  input logic            bank_we_o,
  input logic            bank_val_o
);
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SGL_BYTES);
  localparam logic [XLEN-1:0] STEP_P = XLEN'(2 * SGL_BYTES);

  logic any_eff;
  assign any_eff = freg_we_o || mem_rd_o || mem_wr_o || base_we_o || bank_we_o;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!any_eff && exc_o == 2'd0 && op_o == 3'd0));

  a_r8_exc_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o != 2'd0) |-> !any_eff);

  a_r8_slot_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fpu_dis_i && slot_i)) |-> (exc_o == 2'd3 || exc_o == 2'd1));

  a_r8_plain_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fpu_dis_i && !slot_i)) |-> (exc_o == 2'd2 || exc_o == 2'd1));

  a_r5_even_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> (!src_idx_o[0] && !dst_idx_o[0]));

  a_r3_postinc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o && mem_rd_o) |->
      (base_val_o == $past(base_i) + (pair_o ? STEP_P : STEP_S) && addr_o == $past(base_i)));

  a_r4_predec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o && mem_wr_o) |->
      (base_val_o == addr_o && addr_o == $past(base_i) - (pair_o ? STEP_P : STEP_S)));

  a_r10_bank_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |-> (bank_val_o == !$past(bank_sel_i) && op_o == 3'd5));

  a_r10_bank_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o != 3'd5) |-> (!bank_we_o && !bank_val_o));
endmodule

bind fmv_dec fmv_dec_chk #(
  .XLEN      (XLEN),
  .SGL_BYTES (SGL_BYTES),
  .IDXW      (IDXW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fpu_dis_i  (fpu_dis_i),
  .slot_i     (slot_i),
  .bank_sel_i (bank_sel_i),
  .base_i     (base_i),
  .valid_o    (valid_o),
  .op_o       (op_o),
  .exc_o      (exc_o),
  .pair_o     (pair_o),
  .src_idx_o  (src_idx_o),
  .dst_idx_o  (dst_idx_o),
  .freg_we_o  (freg_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .addr_o     (addr_o),
  .base_we_o  (base_we_o),
  .base_val_o (base_val_o),
  .bank_we_o  (bank_we_o),
  .bank_val_o (bank_val_o)
);

// File: tb/sim_fmv_dec.sv
`timescale 1ns/1ps
module sim_fmv_dec;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        valid_i, fpu_dis, slot, size_m, prec_m, bank_sel;
  logic [15:0] instr;
  logic [31:0] base, r0;

  logic        valid_o, pair_o, src_bank_o, dst_bank_o, freg_we_o, mem_rd_o, mem_wr_o;
  logic        base_we_o, bank_we_o, bank_val_o;
  logic [2:0]  op_o;
  logic [1:0]  exc_o;
  logic [3:0]  src_idx_o, dst_idx_o, base_idx_o;
  logic [31:0] addr_o, base_val_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  fmv_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr),
    .fpu_dis_i(fpu_dis), .slot_i(slot), .size_mode_i(size_m), .prec_mode_i(prec_m),
    .bank_sel_i(bank_sel), .base_i(base), .r0_i(r0),
    .valid_o(valid_o), .op_o(op_o), .exc_o(exc_o), .pair_o(pair_o),
    .src_bank_o(src_bank_o), .src_idx_o(src_idx_o), .dst_bank_o(dst_bank_o),
    .dst_idx_o(dst_idx_o), .freg_we_o(freg_we_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .addr_o(addr_o), .base_idx_o(base_idx_o),
    .base_we_o(base_we_o), .base_val_o(base_val_o), .bank_we_o(bank_we_o),
    .bank_val_o(bank_val_o)
  );

  function automatic logic [90:0] got_vec();
    return {valid_o, op_o, exc_o, pair_o, src_bank_o, src_idx_o, dst_bank_o, dst_idx_o,
            freg_we_o, mem_rd_o, mem_wr_o, addr_o, base_idx_o, base_we_o, base_val_o,
            bank_we_o, bank_val_o};
  endfunction

  // expected result from the requirement text
  function automatic void model(input logic v, input logic [15:0] w, input logic dis,
                                input logic sl, input logic sz, input logic pr,
                                input logic bk, input logic [31:0] b, input logic [31:0] z,
                                output logic [90:0] e, output string tag);
    int kind = 0;   // 1 move 2 load 3 store 4 neg 5 bank
    int amode = 0;  // 1 plain 2 post 3 pre 4 indexed
    logic [1:0]  ex = 2'd0;
    logic        pr2 = 1'b0;
    logic [31:0] step, ad = '0, bv = '0;
    logic        sb = 0, db = 0, fwe = 0, rd = 0, wr = 0, bwe = 0, kwe = 0, kval = 0;
    logic [3:0]  si = '0, di = '0, bi = '0;
    logic [3:0]  n = w[11:8];
    logic [3:0]  m = w[7:4];
    e = '0;
    if (!v) begin tag = "R1"; return; end
    if (w[15:12] == 4'd15) begin
      case (w[3:0])
        4'd12: kind = 1;
        4'd8:  begin kind = 2; amode = 1; end
        4'd9:  begin kind = 2; amode = 2; end
        4'd6:  begin kind = 2; amode = 4; end
        4'd10: begin kind = 3; amode = 1; end
        4'd11: begin kind = 3; amode = 3; end
        4'd7:  begin kind = 3; amode = 4; end
        4'd13: if (m == 4'd4) kind = 4; else if (w[11:4] == 8'hBF) kind = 5;
        default: kind = 0;
      endcase
    end
    if (kind == 0) ex = 2'd1;
    else if (dis) ex = sl ? 2'd3 : 2'd2;
    else if (kind <= 3 ? (sz && pr) : pr) ex = 2'd1;
    if (ex != 0) begin
      e = {1'b1, 3'd0, ex, 85'd0};
      tag = (ex >= 2) ? "R8" : (kind == 0 ? "R7" : "R6");
      return;
    end
    pr2  = (kind <= 3) && sz;
    step = pr2 ? 32'd8 : 32'd4;
    if (kind == 1 || kind == 3) begin
      si = pr2 ? {m[3:1], 1'b0} : m; sb = pr2 & m[0];
    end
    if (kind == 1 || kind == 2) begin
      di = pr2 ? {n[3:1], 1'b0} : n; db = pr2 & n[0];
    end
    if (kind == 4) begin si = n; di = n; end
    fwe = (kind == 1 || kind == 2 || kind == 4);
    rd = (kind == 2); wr = (kind == 3);
    if (rd) bi = m;
    if (wr) bi = n;
    case (amode)
      1: ad = b;
      2: begin ad = b; bwe = 1; bv = b + step; end
      3: begin ad = b - step; bwe = 1; bv = b - step; end
      4: ad = z + b;
      default: ad = '0;
    endcase
    if (kind == 5) begin kwe = 1; kval = ~bk; end
    e = {1'b1, 3'(kind), 2'd0, pr2, sb, si, db, di, fwe, rd, wr, ad, bi, bwe, bv, kwe, kval};
    case (kind)
      1: tag = pr2 ? "R5" : "R2";
      2: tag = pr2 ? "R5" : "R3";
      3: tag = pr2 ? "R5" : "R4";
      4: tag = "R9";
      default: tag = "R10";
    endcase
  endfunction

  task automatic check(input logic [90:0] exp_v, input string tag, input logic [15:0] w);
    logic [90:0] g = got_vec();
    n_chk++;
    if (g !== exp_v) begin
      n_bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, g, exp_v);
    end
  endtask

  task automatic run_vec(input logic v, input logic [15:0] w, input logic dis,
                         input logic sl, input logic sz, input logic pr,
                         input logic bk, input logic [31:0] b, input logic [31:0] z);
    logic [90:0] ev;
    string tg;
    @(negedge clk);
    valid_i = v; instr = w; fpu_dis = dis; slot = sl; size_m = sz; prec_m = pr;
    bank_sel = bk; base = b; r0 = z;
    model(v, w, dis, sl, sz, pr, bk, b, z, ev, tg);
    @(negedge clk);  // one register stage: result visible after the rising edge
    check(ev, tg, w);
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; valid_i = 1'b0; instr = '0; fpu_dis = 0; slot = 0;
    size_m = 0; prec_m = 0; bank_sel = 0; base = '0; r0 = '0;
    repeat (3) @(negedge clk);
    check(91'd0, "R1", 16'h0);  // reset state
    rst_n = 1'b1;

    // idle cycles carry nothing (R1)
    for (int i = 0; i < 4; i++) run_vec(1'b0, 16'hF00C, 0, 0, 0, 0, 1, 32'h40, 32'h4);

    // full sweep of the 1111 opcode space in every mode, FPU enabled
    for (int md = 0; md < 4; md++)
      for (int lo = 0; lo < 16; lo++)
        for (int n = 0; n < 16; n++)
          for (int m = 0; m < 16; m++) begin
            logic [31:0] b = next_rand();
            logic [31:0] z = next_rand();
            run_vec(1'b1, {4'hF, 4'(n), 4'(m), 4'(lo)}, 0, 0, md[1], md[0], n[0] ^ m[0], b, z);
          end

    // disabled FPU, both slot settings, all modes (R8 priority over R6/R7)
    for (int fl = 0; fl < 2; fl++)
      for (int md = 0; md < 4; md++)
        for (int lo = 0; lo < 16; lo++)
          for (int n = 0; n < 16; n += 5) begin
            run_vec(1'b1, {4'hF, 4'(n), 4'h4, 4'(lo)}, 1, fl[0], md[1], md[0], 0, next_rand(), next_rand());
            run_vec(1'b1, {4'hF, 4'(n), 4'hF, 4'(lo)}, 1, fl[0], md[1], md[0], 1, next_rand(), next_rand());
          end
    run_vec(1'b1, 16'hFBFD, 1, 1, 0, 0, 1, 32'h0, 32'h0);  // R8 slot on bank toggle

    // words outside the 1111 space (R7), with and without disable
    for (int t = 0; t < 15; t++)
      for (int k = 0; k < 8; k++) begin
        logic [31:0] rv = next_rand();
        run_vec(1'b1, {4'(t), rv[11:0]}, k[0], k[1], k[2], 0, 0, next_rand(), next_rand());
      end

    // address wrap corners (R4, R3, R5)
    run_vec(1'b1, 16'hF23B, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0);
    run_vec(1'b1, 16'hF23B, 0, 0, 1, 0, 0, 32'h0000_0004, 32'h0);
    run_vec(1'b1, 16'hF329, 0, 0, 0, 0, 0, 32'hFFFF_FFFC, 32'h0);
    run_vec(1'b1, 16'hF229, 0, 0, 1, 0, 0, 32'hFFFF_FFF8, 32'h0);
    run_vec(1'b1, 16'hF456, 0, 0, 0, 0, 0, 32'hFFFF_FFF0, 32'h20);

    // bank toggle with both starting values, then back to idle (R10, R1)
    run_vec(1'b1, 16'hFBFD, 0, 0, 1, 0, 0, 32'h0, 32'h0);
    run_vec(1'b1, 16'hFBFD, 0, 0, 0, 0, 1, 32'h0, 32'h0);
    run_vec(1'b0, 16'hFBFD, 0, 0, 0, 0, 1, 32'h0, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule